// File: doc/BRIEF.md
# Dual-Slot Transmit Packet Scheduler

This block arbitrates two transmit packets that share the transmit buffer and launches them strictly in alternation: slot I, then slot II, then slot I again. The host stores a packet's bytes in the buffer and writes its 16-bit byte count into a two-byte length register. It then sets the request bit of the transmit control register. The scheduler latches the active slot's start address, its length and two framing controls, and gives a one-cycle start pulse to the MAC transmit engine. When the MAC reports completion, the scheduler files the MAC's status word under the slot that just finished, drops the request bit and moves to the other slot.

Slot I always starts at buffer address 0. Slot II starts at the address just past the bytes of the most recent slot I packet. The host may load the other slot's data while a packet is on the wire. It must not write the next length and request until the busy bit reads 0.

The controller has four states. IDLE waits for a request. LAUNCH lasts one cycle and drives the start pulse. SEND waits for the MAC's done. RETIRE lasts one cycle, after which the slot has changed. The transitions are: IDLE to LAUNCH on a control write with bit 0 set; LAUNCH to SEND unconditionally; SEND to RETIRE on MAC done; RETIRE to IDLE unconditionally.

Top module: `tx_slot_sched`

## Requirements
- R1: After reset the current slot is I (`cur_slot`=0), the state is IDLE (`ctrl_rd` bit 0 = 0), `tx_start`=0, `tx_addr`=0 and both status outputs are 0.
- R2: A write to address 0xFC loads the low byte of the staged length, and a write to 0xFD loads the high byte. The staged value becomes `tx_len` at the next launch.
- R3: In IDLE, a write to address 0x02 with data bit 0 = 1 makes `tx_start` high for exactly one cycle, in the cycle after the write. From the cycle after that until the return to IDLE, `ctrl_rd` bit 0 reads 1.
- R4: `tx_addr` is 0 for a slot I launch. For a slot II launch it is the low ADDR_W bits of the byte count used by the most recent slot I launch.
- R5: Data bit 1 (CRC inhibit) and data bit 2 (pad inhibit) of the launching control write are latched. They are held on `tx_crc_inh` and `tx_pad_inh` and read back on `ctrl_rd` bits 1 and 2.
- R6: In SEND, a `mac_done` pulse stores `mac_status` into `stat_slot0` (register 0x03) if the current slot is I, or into `stat_slot1` (register 0x04) if it is II. The new value is visible in the cycle after the pulse.
- R7: One cycle after the status capture, `ctrl_rd` bit 0 returns to 0 and `cur_slot` toggles, so launches alternate I, II, I, II.
- R8: A control write while busy has no effect: there is no new start pulse, and the inhibit outputs keep their values.
- R9: A `mac_done` pulse outside SEND leaves both status outputs unchanged.
- R10: `tx_len` and `tx_addr` stay fixed for the whole transmission, even if the length register is rewritten meanwhile.
- R11: A control write in IDLE with data bit 0 = 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| mac_done | input | 1 | MAC finished the current packet (one-cycle pulse) |
| mac_status | input | STAT_W | MAC completion status |
| tx_start | output | 1 | One-cycle launch pulse to the MAC |
| tx_addr | output | ADDR_W | Start address of the active slot |
| tx_len | output | 16 | Byte count of the active packet |
| tx_crc_inh | output | 1 | Latched CRC-inhibit control |
| tx_pad_inh | output | 1 | Latched pad-inhibit control |
| ctrl_rd | output | 8 | Control readback: bit 0 busy, bit 1 CRC inhibit, bit 2 pad inhibit |
| stat_slot0 | output | STAT_W | Status of the last slot I packet |
| stat_slot1 | output | STAT_W | Status of the last slot II packet |
| cur_slot | output | 1 | Current slot (0 = I, 1 = II) |

## Verification
A wrong slot register is visible at the next launch: the start address is 0 where the previous slot I length was expected, or the reverse. It is also visible one cycle after the status capture, when the status lands in the wrong register. A state register stuck in SEND or LAUNCH shows within one cycle as a busy bit that never clears or a start pulse longer than one cycle. A missing busy guard shows in the cycle after an illegal control write, as a second start pulse or changed inhibit outputs.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_SEND   = 2'd2,
        ST_RETIRE = 2'd3
    } txs_state_e;

    localparam logic [7:0] ADR_CTRL   = 8'h02;
    localparam logic [7:0] ADR_LEN_LO = 8'hFC;
    localparam logic [7:0] ADR_LEN_HI = 8'hFD;
endpackage

// File: rtl/txs_fsm.sv
module txs_fsm
    import txs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_req,
    input  logic       mac_done,
    output txs_state_e state,
    output logic       launch,
    output logic       capture,
    output logic       tx_start,
    output logic       busy,
    output logic       slot
);
    txs_state_e state_q, state_d;
    logic       slot_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_req)   state_d = ST_LAUNCH;
            ST_LAUNCH:               state_d = ST_SEND;
            ST_SEND:   if (mac_done) state_d = ST_RETIRE;
            ST_RETIRE:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     slot_q <= 1'b0;
        else if (state_q == ST_RETIRE) slot_q <= ~slot_q;
    end

    always_comb begin
        state    = state_q;
        slot     = slot_q;
        launch   = (state_q == ST_IDLE) && go_req;
        capture  = (state_q == ST_SEND) && mac_done;
        tx_start = (state_q == ST_LAUNCH);
        busy     = (state_q != ST_IDLE);
    end

    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    a_r3_launch_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> tx_start);
    a_r7_slot_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETIRE) |=> (slot_q != $past(slot_q)));
    a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req) |=> !tx_start);
endmodule

// File: rtl/txs_slots.sv
module txs_slots #(
    parameter int ADDR_W = 12,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_wr_lo,
    input  logic              len_wr_hi,
    input  logic [7:0]        wdata,
    input  logic              launch,
    input  logic              capture,
    input  logic              slot,
    input  logic              in_send,
    input  logic [STAT_W-1:0] mac_status,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [15:0]       tx_len,
    output logic [1:0]        flags,
    output logic [STAT_W-1:0] stat0,
    output logic [STAT_W-1:0] stat1
);
    localparam int LEN_W = 16;

    logic [LEN_W-1:0]  len_stage;
    logic [ADDR_W-1:0] base_b;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_stage <= '0;
        end else begin
            if (len_wr_lo) len_stage[7:0]  <= wdata;
            if (len_wr_hi) len_stage[15:8] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_addr <= '0;
            tx_len  <= '0;
            flags   <= '0;
            base_b  <= '0;
        end else if (launch) begin
            tx_len  <= len_stage;
            flags   <= wdata[2:1];
            tx_addr <= slot ? base_b : '0;
            if (!slot) base_b <= len_stage[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat0 <= '0;
            stat1 <= '0;
        end else if (capture) begin
            if (slot) stat1 <= mac_status;
            else      stat0 <= mac_status;
        end
    end

    a_r10_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        in_send |=> ($stable(tx_len) && $stable(tx_addr)));
    a_r6_one_status_moves: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ($stable(stat0) || $stable(stat1)));
endmodule

// File: rtl/tx_slot_sched.sv
module tx_slot_sched
    import txs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              mac_done,
    input  logic [STAT_W-1:0] mac_status,
    output logic              tx_start,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [15:0]       tx_len,
    output logic              tx_crc_inh,
    output logic              tx_pad_inh,
    output logic [7:0]        ctrl_rd,
    output logic [STAT_W-1:0] stat_slot0,
    output logic [STAT_W-1:0] stat_slot1,
    output logic              cur_slot
);
    txs_state_e state;
    logic       go_req, launch, capture, busy, slot;
    logic [1:0] flags;

    assign go_req = reg_wr && (reg_addr == ADR_CTRL) && reg_wdata[0];

    txs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_req   (go_req),
        .mac_done (mac_done),
        .state    (state),
        .launch   (launch),
        .capture  (capture),
        .tx_start (tx_start),
        .busy     (busy),
        .slot     (slot)
    );

    txs_slots #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_wr_lo  (reg_wr && (reg_addr == ADR_LEN_LO)),
        .len_wr_hi  (reg_wr && (reg_addr == ADR_LEN_HI)),
        .wdata      (reg_wdata),
        .launch     (launch),
        .capture    (capture),
        .slot       (slot),
        .in_send    (state == ST_SEND),
        .mac_status (mac_status),
        .tx_addr    (tx_addr),
        .tx_len     (tx_len),
        .flags      (flags),
        .stat0      (stat_slot0),
        .stat1      (stat_slot1)
    );

    assign tx_crc_inh = flags[0];
    assign tx_pad_inh = flags[1];
    assign ctrl_rd    = {5'b0, flags, busy};
    assign cur_slot   = slot;

    a_r9_stray_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_done && state != ST_SEND) |=> ($stable(stat_slot0) && $stable(stat_slot1)));
    a_r8_flags_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && state != ST_IDLE) |=> $stable(flags));
endmodule

// File: tb/tx_slot_sched_bench.sv
`timescale 1ns/1ps
module tx_slot_sched_bench;
    localparam int AW = 12;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          mac_done = 1'b0;
    logic [SW-1:0] mac_status = '0;
    logic          tx_start, tx_crc_inh, tx_pad_inh, cur_slot;
    logic [AW-1:0] tx_addr;
    logic [15:0]   tx_len;
    logic [7:0]    ctrl_rd;
    logic [SW-1:0] stat_slot0, stat_slot1;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_slot_sched #(.ADDR_W(AW), .STAT_W(SW)) u_tx_slot_sched (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mac_done(mac_done), .mac_status(mac_status),
        .tx_start(tx_start), .tx_addr(tx_addr), .tx_len(tx_len),
        .tx_crc_inh(tx_crc_inh), .tx_pad_inh(tx_pad_inh), .ctrl_rd(ctrl_rd),
        .stat_slot0(stat_slot0), .stat_slot1(stat_slot1), .cur_slot(cur_slot)
    );

    // {length[15:0], status[7:0], ctrl data[7:0]}
    localparam logic [31:0] VEC [6] = '{
        {16'h0040, 8'hA1, 8'h01},
        {16'h0123, 8'hB2, 8'h03},
        {16'h05EA, 8'hC3, 8'h05},
        {16'h0010, 8'hD4, 8'h07},
        {16'h0BFF, 8'hE5, 8'h01},
        {16'h003C, 8'h96, 8'h03}
    };

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic done_pulse(input logic [7:0] st);
        @(negedge clk);
        mac_done = 1'b1; mac_status = st;
        @(negedge clk);
        mac_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] last_len_a;
        last_len_a = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 slot", cur_slot, 0);
        check("R1 busy", ctrl_rd[0], 0);
        check("R1 start", tx_start, 0);
        check("R1 addr", tx_addr, 0);
        check("R1 stat0", stat_slot0, 0);
        check("R1 stat1", stat_slot1, 0);

        for (int i = 0; i < 6; i++) begin
            logic [15:0] len;
            logic [7:0]  st, cd;
            logic        s;
            len = VEC[i][31:16]; st = VEC[i][15:8]; cd = VEC[i][7:0];
            s = cur_slot;
            check("R7 alternation", s, i % 2);
            wr(8'hFC, len[7:0]);                    // R2
            wr(8'hFD, len[15:8]);
            wr(8'h02, cd);
            check("R3 start pulse", tx_start, 1);
            check("R2 length", tx_len, len);
            check("R4 address", tx_addr, s ? last_len_a[AW-1:0] : 0);
            check("R5 crc inh", tx_crc_inh, cd[1]);
            check("R5 pad inh", tx_pad_inh, cd[2]);
            check("R5 readback", ctrl_rd[2:1], cd[2:1]);
            if (!s) last_len_a = len;
            @(negedge clk);
            check("R3 pulse ends", tx_start, 0);
            check("R3 busy", ctrl_rd[0], 1);
            done_pulse(st);
            check("R6 status", s ? stat_slot1 : stat_slot0, st);
            @(negedge clk);
            check("R7 busy clear", ctrl_rd[0], 0);
            check("R7 toggle", cur_slot, !s);
        end

        // R11: request bit 0 = 0 in IDLE starts nothing
        wr(8'h02, 8'h06);
        check("R11 no start", tx_start, 0);
        @(negedge clk);
        check("R11 idle", ctrl_rd[0], 0);

        // R9: stray done in IDLE
        done_pulse(8'h5A);
        check("R9 stat0", stat_slot0, 8'hE5);
        check("R9 stat1", stat_slot1, 8'h96);

        // R8 / R10: writes during a transmission
        wr(8'hFC, 8'h20);
        wr(8'hFD, 8'h00);
        wr(8'h02, 8'h01);
        check("R3 start", tx_start, 1);
        @(negedge clk);
        wr(8'hFC, 8'h77);
        wr(8'hFD, 8'h01);
        wr(8'h02, 8'h07);
        check("R8 no restart", tx_start, 0);
        check("R8 crc held", tx_crc_inh, 0);
        check("R8 pad held", tx_pad_inh, 0);
        check("R10 len held", tx_len, 16'h0020);
        check("R10 addr held", tx_addr, 0);
        check("R9 stat untouched", stat_slot0, 8'hE5);
        done_pulse(8'h33);
        check("R6 slot I status", stat_slot0, 8'h33);
        @(negedge clk);
        check("R7 toggle", cur_slot, 1);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 slot after reset", cur_slot, 0);
        check("R1 stat0 after reset", stat_slot0, 0);
        check("R1 busy after reset", ctrl_rd[0], 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule